// File: doc/BRIEF.md
# Four-Port GPIO Bank Register File

This block holds the control state for one bank of general-purpose pins: four ports of eight pins each. Every port has three writable control registers (function select, drive enable and drive value) and one read-only register that shows the synchronized level of the pads. The control registers feed the per-pin outputs directly. Software reaches all of them through a small synchronous register bus.

Each writable register has two addresses. A write to the plain address replaces all eight bits. A write to the masked address, which lies 0x800 above the plain one, changes only the pins selected by a mask carried in the same bus word. Because of this, one agent can flip a single pin without reading the register first, and it cannot undo another agent's recent change to a neighbouring pin. Pad levels pass through a two-stage synchronizer before software can read them.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every register is zero, so all of `pin_gpio_sel`, `pin_oe` and `pin_out` are low and reads return 0.
- R2: A write to a plain address replaces the whole 8-bit register. The register is function select at offset 0x00, drive enable at 0x10 or drive value at 0x20, plus 4 times the port number. The new value appears on the pins right after the write edge. Pin index is port*8 + bit.
- R3: A write to a masked address (plain offset + 0x800) updates only those pins whose bit in wdata[15:8] is 1. Each updated pin takes the matching bit of wdata[7:0], and all other pins keep their value.
- R4: A masked write with wdata[15:8] equal to zero changes nothing.
- R5: A read returns the addressed register in bus_rdata[7:0] on the edge after the address is presented, with bits 31:8 zero. A masked address reads the same value as its plain address.
- R6: The input register (offset 0x30 + 4*port) shows each pad level in the bit matching the pin's bit index. A pad change reaches the register after two clock edges, so a read shows it on the third edge.
- R7: Writes to the input register, at its plain or masked address, change no output and no stored value.
- R8: A write to one port or register leaves every other port and register unchanged.
- R9: Addresses with any of bits 10:6 set are unmapped: they read 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address; bit 11 selects the masked alias |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data; [15:8] mask, [7:0] values |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Asynchronous pad levels, pin index port*8+bit |
| pin_gpio_sel | output | 32 | Function-select bit per pin |
| pin_oe | output | 32 | Drive enable per pin |
| pin_out | output | 32 | Drive value per pin |

## Verification
Control writes take effect on the write edge, so the bench checks the pin vectors half a cycle later, at the falling edge that follows. Read data is registered and is compared at the falling edge after the edge that captures the address. Pad changes are due after two edges in the input register and on the third edge on the read bus. The bench issues back-to-back reads after a pad change and expects the old value for the first two and the new value from the third on.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [1:0] {
    GRP_SEL = 2'd0,
    GRP_OE  = 2'd1,
    GRP_OUT = 2'd2,
    GRP_IN  = 2'd3
  } grp_e;

  localparam int BUS_W      = 32;
  localparam int ADDR_W     = 12;
  localparam int MASK_LSB   = 8;
  localparam int ALIAS_BIT  = 11;
  localparam int GRP_LSB    = 4;
  localparam int HOLE_LSB   = 6;
  localparam int HOLE_MSB   = 10;
  localparam int PORT_LSB   = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      wr_stb,
  input  logic [PINS-1:0] wr_mask,
  input  logic [PINS-1:0] wr_val,
  output logic [PINS-1:0] sel_q,
  output logic [PINS-1:0] oe_q,
  output logic [PINS-1:0] out_q
);
  logic [PINS-1:0] regs [3];

  for (genvar k = 0; k < 3; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[k] <= '0;
      end else if (wr_stb[k]) begin
        regs[k] <= (regs[k] & ~wr_mask) | (wr_val & wr_mask);
      end
    end
  end

  assign sel_q = regs[0];
  assign oe_q  = regs[1];
  assign out_q = regs[2];
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int PORTS = 4,
  parameter int PINS  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic [BUS_W-1:0]      bus_rdata,
  input  logic [PORTS*PINS-1:0] pad_in,
  output logic [PORTS*PINS-1:0] pin_gpio_sel,
  output logic [PORTS*PINS-1:0] pin_oe,
  output logic [PORTS*PINS-1:0] pin_out
);
  localparam int NPIN   = PORTS * PINS;
  localparam int PORT_W = (PORTS > 1) ? $clog2(PORTS) : 1;

  grp_e              acc_grp;
  logic [PORT_W-1:0] acc_port;
  logic              acc_masked;
  logic              acc_mapped;
  logic [PINS-1:0]   acc_mask;
  logic [PINS-1:0]   acc_val;
  logic [NPIN-1:0]   in_sync;
  logic [PINS-1:0]   sel_q [PORTS];
  logic [PINS-1:0]   oe_q  [PORTS];
  logic [PINS-1:0]   out_q [PORTS];
  logic [PINS-1:0]   rd_sel;

  assign acc_grp    = grp_e'(bus_addr[GRP_LSB +: 2]);
  assign acc_port   = bus_addr[PORT_LSB +: PORT_W];
  assign acc_masked = bus_addr[ALIAS_BIT];
  assign acc_mapped = (bus_addr[HOLE_MSB:HOLE_LSB] == '0);
  assign acc_mask   = acc_masked ? bus_wdata[MASK_LSB +: PINS] : '1;
  assign acc_val    = bus_wdata[PINS-1:0];

  gpio_sync #(.W(NPIN)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pad_in),
    .sync_out (in_sync)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic       hit;
    logic [2:0] stb;

    assign hit    = bus_we && acc_mapped && (acc_port == PORT_W'(p));
    assign stb[0] = hit && (acc_grp == GRP_SEL);
    assign stb[1] = hit && (acc_grp == GRP_OE);
    assign stb[2] = hit && (acc_grp == GRP_OUT);

    gpio_port_regs #(.PINS(PINS)) u_port (
      .clk     (clk),
      .rst     (rst),
      .wr_stb  (stb),
      .wr_mask (acc_mask),
      .wr_val  (acc_val),
      .sel_q   (sel_q[p]),
      .oe_q    (oe_q[p]),
      .out_q   (out_q[p])
    );

    assign pin_gpio_sel[p*PINS +: PINS] = sel_q[p];
    assign pin_oe[p*PINS +: PINS]       = oe_q[p];
    assign pin_out[p*PINS +: PINS]      = out_q[p];
  end

  always_comb begin
    rd_sel = '0;
    if (acc_mapped && (int'(acc_port) < PORTS)) begin
      case (acc_grp)
        GRP_SEL: rd_sel = sel_q[acc_port];
        GRP_OE:  rd_sel = oe_q[acc_port];
        GRP_OUT: rd_sel = out_q[acc_port];
        default: rd_sel = in_sync[int'(acc_port)*PINS +: PINS];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= {{(BUS_W-PINS){1'b0}}, rd_sel};
    end
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int PORTS = 4,
  parameter int PINS  = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_we,
  input logic [BUS_W-1:0]      bus_wdata,
  input logic [BUS_W-1:0]      bus_rdata,
  input logic [PORTS*PINS-1:0] pad_in,
  input logic [PORTS*PINS-1:0] pin_gpio_sel,
  input logic [PORTS*PINS-1:0] pin_oe,
  input logic [PORTS*PINS-1:0] pin_out
);
  localparam int PORT_W = (PORTS > 1) ? $clog2(PORTS) : 1;

  logic              unmapped;
  logic              to_input;
  logic              zero_mask;
  logic              ctl_write;
  logic [1:0]        grp_now;
  logic [PORT_W-1:0] port_now;
  logic [PINS-1:0]   mask_now;
  logic [PINS-1:0]   slice_at_wr;
  logic [PINS-1:0]   slice_cur;
  logic              pw_hit;
  logic [1:0]        pw_grp;
  logic [PORT_W-1:0] pw_port;
  logic [PINS-1:0]   pw_mask;
  logic [PINS-1:0]   pw_val;
  logic [PINS-1:0]   pw_old;

  assign unmapped  = (bus_addr[HOLE_MSB:HOLE_LSB] != '0);
  assign grp_now   = bus_addr[GRP_LSB +: 2];
  assign port_now  = bus_addr[PORT_LSB +: PORT_W];
  assign to_input  = !unmapped && (grp_now == 2'd3);
  assign zero_mask = bus_addr[ALIAS_BIT] && (bus_wdata[MASK_LSB +: PINS] == '0);
  assign ctl_write = bus_we && !unmapped && (grp_now != 2'd3);
  assign mask_now  = bus_addr[ALIAS_BIT] ? bus_wdata[MASK_LSB +: PINS] : '1;

  function automatic logic [PINS-1:0] pick(input logic [1:0] g, input logic [PORT_W-1:0] p,
                                           input logic [PORTS*PINS-1:0] s,
                                           input logic [PORTS*PINS-1:0] o,
                                           input logic [PORTS*PINS-1:0] d);
    case (g)
      2'd0:    pick = s[int'(p)*PINS +: PINS];
      2'd1:    pick = o[int'(p)*PINS +: PINS];
      default: pick = d[int'(p)*PINS +: PINS];
    endcase
  endfunction

  assign slice_at_wr = pick(grp_now, port_now, pin_gpio_sel, pin_oe, pin_out);
  assign slice_cur   = pick(pw_grp, pw_port, pin_gpio_sel, pin_oe, pin_out);

  always_ff @(posedge clk) begin
    if (rst) begin
      pw_hit  <= 1'b0;
      pw_grp  <= '0;
      pw_port <= '0;
      pw_mask <= '0;
      pw_val  <= '0;
      pw_old  <= '0;
    end else begin
      pw_hit  <= ctl_write;
      pw_grp  <= grp_now;
      pw_port <= port_now;
      pw_mask <= mask_now;
      pw_val  <= bus_wdata[PINS-1:0];
      pw_old  <= slice_at_wr;
    end
  end

  // R2 and R3: written slice merges new values under the mask
  a_r3_write_merge: assert property (@(posedge clk) disable iff (rst)
    pw_hit |-> slice_cur == ((pw_old & ~pw_mask) | (pw_val & pw_mask)));

  a_r4_zero_mask_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_we && zero_mask) |=> ($stable(pin_out) && $stable(pin_oe) && $stable(pin_gpio_sel)));

  a_r7_input_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_we && to_input) |=> ($stable(pin_out) && $stable(pin_oe) && $stable(pin_gpio_sel)));

  a_r9_unmapped_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_we && unmapped) |=> ($stable(pin_out) && $stable(pin_oe) && $stable(pin_gpio_sel)));

  a_r9_unmapped_read_zero: assert property (@(posedge clk) disable iff (rst)
    unmapped |=> (bus_rdata == '0));

  a_r5_rdata_high_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[BUS_W-1:PINS] == '0);
endmodule

bind gpio_bank_regs gpio_bank_chk #(.PORTS(PORTS), .PINS(PINS)) u_chk (.*);

// File: tb/gpio_bank_regs_bench.sv
module gpio_bank_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pin_gpio_sel, pin_oe, pin_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] m_reg [3][4];

  always #4 clk = ~clk;

  gpio_bank_regs u_gpio_bank_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pin_gpio_sel(pin_gpio_sel), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_vec(input int g);
    logic [31:0] v;
    for (int p = 0; p < 4; p++) v[p*8 +: 8] = m_reg[g][p];
    return v;
  endfunction

  task automatic check_pins(input string req);
    check({req, " sel"}, pin_gpio_sel, model_vec(0));
    check({req, " oe"},  pin_oe,       model_vec(1));
    check({req, " out"}, pin_out,      model_vec(2));
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    for (int g = 0; g < 3; g++) for (int p = 0; p < 4; p++) m_reg[g][p] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check_pins("R1 reset");
    bus_read(12'h020, rd);
    check("R1 reset read", rd, 32'h0);

    // R2 plain writes, sweep every port and control register; R8 isolation
    for (int p = 0; p < 4; p++) begin
      for (int g = 0; g < 3; g++) begin
        logic [7:0] v;
        v = 8'((p * 37 + g * 91 + 13) & 8'hff);
        m_reg[g][p] = v;
        bus_write(12'(g * 16 + p * 4), {16'hFFFF, 8'h00, v} ^ 32'hABCD_0000);
        check_pins("R2 R8 plain write");
        bus_read(12'(g * 16 + p * 4), rd);
        check("R5 plain read", rd, {24'h0, v});
        bus_read(12'(12'h800 + g * 16 + p * 4), rd);
        check("R5 masked alias read", rd, {24'h0, v});
      end
    end

    // R3 masked writes over a set of masks; R4 zero mask
    for (int k = 0; k < 6; k++) begin
      logic [7:0] msk, val;
      msk = (k == 0) ? 8'h00 : (k == 1) ? 8'h01 : (k == 2) ? 8'h80 :
            (k == 3) ? 8'hA5 : (k == 4) ? 8'hFF : 8'h3C;
      val = 8'((k * 53 + 7) & 8'hff);
      for (int p = 0; p < 4; p++) begin
        for (int g = 0; g < 3; g++) begin
          m_reg[g][p] = (m_reg[g][p] & ~msk) | (val & msk);
          bus_write(12'(12'h800 + g * 16 + p * 4), {16'h0, msk, val});
          if (msk == 8'h00) check_pins("R4 zero mask");
          else check_pins("R3 masked write");
        end
      end
    end

    // R7 writes to input register ignored
    bus_write(12'h030, 32'h0000_00FF);
    check_pins("R7 plain input write");
    bus_write(12'h83C, 32'h0000_FFFF);
    check_pins("R7 masked input write");
    bus_read(12'h030, rd);
    check("R7 input read unchanged", rd, 32'h0);

    // R9 unmapped
    bus_write(12'h040, 32'h0000_FFFF);
    check_pins("R9 unmapped write 0x040");
    bus_write(12'h420, 32'h0000_FFFF);
    check_pins("R9 unmapped write 0x420");
    bus_read(12'h060, rd);
    check("R9 unmapped read", rd, 32'h0);

    // R6 input sync latency and bit placement
    pad_in = 32'hC3A5_5A3C;
    bus_read(12'h030, rd);
    check("R6 first edge old", rd, 32'h0);
    bus_read(12'h034, rd);
    check("R6 second edge old", rd, 32'h0);
    bus_read(12'h038, rd);
    check("R6 third edge new port2", rd, 32'h0000_00A5);
    bus_read(12'h03C, rd);
    check("R6 port3", rd, 32'h0000_00C3);
    bus_read(12'h830, rd);
    check("R6 port0 via alias", rd, 32'h0000_003C);
    bus_read(12'h034, rd);
    check("R6 port1", rd, 32'h0000_005A);
    check_pins("R8 after input activity");

    // R1 reset again clears everything
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int g = 0; g < 3; g++) for (int p = 0; p < 4; p++) m_reg[g][p] = 8'h00;
    check_pins("R1 second reset");

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule